// File: doc/BRIEF.md
# Byte Rotate, Shift and Bit Unit

This is a purely combinational datapath slice that transforms one byte with the help of an incoming carry flag. It takes an operand, a 4-bit operation select, a 3-bit bit index and the current Z, N, H and C flags. It returns the transformed byte, a strobe that says whether the byte should be written back, and the next value of all four flags. The surrounding core fetches the operand from a register or memory, and it commits the result and flags. Neither of those steps is part of this block.

The unit covers four groups of operations:
- Circular rotates, rotates through carry and the three shifts.
- A nibble exchange.
- Four short accumulator rotates. They move data exactly like the general rotates but always report a clear zero flag.
- Three single-bit operations: test, set and clear.

Top module: `rsb_unit`

## Requirements
Operation codes on `op_sel`: 0 rotate-left circular, 1 rotate-right circular, 2 rotate-left through carry, 3 rotate-right through carry, 4 shift-left arithmetic, 5 shift-right arithmetic, 6 shift-right logical, 7 nibble exchange, 8 to 11 the accumulator forms of codes 0 to 3, 12 bit test, 13 bit set, 14 bit clear, 15 no operation.

- R1: Codes 0 and 8 produce {a[6:0],a[7]}, and C becomes a[7]. Codes 1 and 9 produce {a[0],a[7:1]}, and C becomes a[0].
- R2: Codes 2 and 10 produce {a[6:0],c_in}, and C becomes a[7]. Codes 3 and 11 produce {c_in,a[7:1]}, and C becomes a[0].
- R3: Code 4 produces {a[6:0],0}, and C becomes a[7].
- R4: Code 5 produces {a[7],a[7:1]}. Code 6 produces {0,a[7:1]}. In both cases C becomes a[0].
- R5: For codes 0 to 7, Z is set exactly when the result is zero, and N and H are 0.
- R6: For codes 8 to 11, Z, N and H are all 0, whatever the result.
- R7: Code 7 produces {a[3:0],a[7:4]} and clears C.
- R8: Code 12 sets Z when the indexed bit of the operand is 0. It clears N, sets H, keeps C equal to `c_in`, drives the operand unchanged on `result`, and holds `result_we` low.
- R9: Code 13 forces the indexed bit to 1 and code 14 forces it to 0. The other bits are unchanged, and all four flags equal their inputs.
- R10: `bit_idx` 0 selects the least significant bit and 7 the most significant.
- R11: Code 15 drives the operand on `result`, holds `result_we` low and passes all flags through.
- R12: `result_we` is high for every code from 0 to 11, 13 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 8 | Byte to transform |
| bit_idx | input | 3 | Bit position for codes 12 to 14 |
| carry_in | input | 1 | Current C flag |
| z_in | input | 1 | Current Z flag |
| n_in | input | 1 | Current N flag |
| h_in | input | 1 | Current H flag |
| op_sel | input | 4 | Operation code |
| result | output | 8 | Transformed byte |
| result_we | output | 1 | Result should be written back |
| z_out | output | 1 | Next Z flag |
| n_out | output | 1 | Next N flag |
| h_out | output | 1 | Next H flag |
| c_out | output | 1 | Next C flag |

## Verification
Every output is a combinational function of the inputs present in the same cycle, so each result is due zero cycles after its stimulus. The bench applies inputs just after a rising edge and samples at the following falling edge, which leaves half a period for settling with no register in between. A hand-computed vector table covers each code and its edge operands. An exhaustive sweep then covers every code, operand, carry and index, checked against a model written from the requirements.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [3:0] {
    OP_ROL_C  = 4'd0,
    OP_ROR_C  = 4'd1,
    OP_ROL_K  = 4'd2,
    OP_ROR_K  = 4'd3,
    OP_SHL_A  = 4'd4,
    OP_SHR_A  = 4'd5,
    OP_SHR_L  = 4'd6,
    OP_NSWAP  = 4'd7,
    OP_AROL_C = 4'd8,
    OP_AROR_C = 4'd9,
    OP_AROL_K = 4'd10,
    OP_AROR_K = 4'd11,
    OP_BTEST  = 4'd12,
    OP_BSET   = 4'd13,
    OP_BCLR   = 4'd14,
    OP_NONE   = 4'd15
  } rsb_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } rsb_flags_t;
endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
  import rsb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rsb_op_e           op,
  input  logic [DATA_W-1:0] din,
  input  logic              cin,
  output logic [DATA_W-1:0] dout,
  output logic              cout,
  output logic              is_shift,
  output logic              is_acc
);
  localparam int MSB = DATA_W - 1;
  localparam int NIB = DATA_W / 2;

  logic go_left;
  logic fill;

  always_comb begin
    go_left  = 1'b0;
    fill     = 1'b0;
    is_shift = 1'b1;
    is_acc   = 1'b0;
    unique case (op)
      OP_ROL_C:  begin go_left = 1'b1; fill = din[MSB]; end
      OP_AROL_C: begin go_left = 1'b1; fill = din[MSB]; is_acc = 1'b1; end
      OP_ROL_K:  begin go_left = 1'b1; fill = cin; end
      OP_AROL_K: begin go_left = 1'b1; fill = cin; is_acc = 1'b1; end
      OP_SHL_A:  begin go_left = 1'b1; fill = 1'b0; end
      OP_ROR_C:  fill = din[0];
      OP_AROR_C: begin fill = din[0]; is_acc = 1'b1; end
      OP_ROR_K:  fill = cin;
      OP_AROR_K: begin fill = cin; is_acc = 1'b1; end
      OP_SHR_A:  fill = din[MSB];
      OP_SHR_L:  fill = 1'b0;
      OP_NSWAP:  fill = 1'b0;
      default:   is_shift = 1'b0;
    endcase
  end

  always_comb begin
    if (op == OP_NSWAP) begin
      dout = {din[NIB-1:0], din[DATA_W-1:NIB]};
      cout = 1'b0;
    end else if (go_left) begin
      dout = {din[MSB-1:0], fill};
      cout = din[MSB];
    end else begin
      dout = {fill, din[MSB:1]};
      cout = din[0];
    end
  end
endmodule

// File: rtl/rsb_bitops.sv
module rsb_bitops
  import rsb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  rsb_op_e           op,
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] dout,
  output logic              bit_val
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask[i] = (idx == IDX_W'(i));
  end

  assign bit_val = |(din & mask);

  always_comb begin
    unique case (op)
      OP_BSET: dout = din | mask;
      OP_BCLR: dout = din & ~mask;
      default: dout = din;
    endcase
  end

  // R10
  always_comb begin
    idx_onehot_chk: assert ($countones(mask) == 1);
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              carry_in,
  input  logic              z_in,
  input  logic              n_in,
  input  logic              h_in,
  input  logic [3:0]        op_sel,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              z_out,
  output logic              n_out,
  output logic              h_out,
  output logic              c_out
);
  localparam int MSB = DATA_W - 1;

  rsb_op_e           op;
  logic [DATA_W-1:0] sh_dout;
  logic [DATA_W-1:0] bo_dout;
  logic              sh_cout;
  logic              sh_valid;
  logic              sh_acc;
  logic              bo_bit;
  rsb_flags_t        nxt;

  assign op = rsb_op_e'(op_sel);

  rsb_shifter #(.DATA_W(DATA_W)) u_shift (
    .op      (op),
    .din     (operand),
    .cin     (carry_in),
    .dout    (sh_dout),
    .cout    (sh_cout),
    .is_shift(sh_valid),
    .is_acc  (sh_acc)
  );

  rsb_bitops #(.DATA_W(DATA_W)) u_bits (
    .op     (op),
    .din    (operand),
    .idx    (bit_idx),
    .dout   (bo_dout),
    .bit_val(bo_bit)
  );

  always_comb begin
    nxt       = '{z: z_in, n: n_in, h: h_in, c: carry_in};
    result    = operand;
    result_we = 1'b0;
    if (sh_valid) begin
      result    = sh_dout;
      result_we = 1'b1;
      nxt.z     = sh_acc ? 1'b0 : ~|sh_dout;
      nxt.n     = 1'b0;
      nxt.h     = 1'b0;
      nxt.c     = sh_cout;
    end else if (op == OP_BTEST) begin
      nxt.z = ~bo_bit;
      nxt.n = 1'b0;
      nxt.h = 1'b1;
    end else if (op == OP_BSET || op == OP_BCLR) begin
      result    = bo_dout;
      result_we = 1'b1;
    end
  end

  assign z_out = nxt.z;
  assign n_out = nxt.n;
  assign h_out = nxt.h;
  assign c_out = nxt.c;

  always_comb begin
    // R1
    if (op == OP_ROL_C || op == OP_AROL_C)
      rol_wrap_chk: assert (result[0] == c_out && c_out == operand[MSB]);
    // R4
    if (op == OP_SHR_A)
      sra_sign_chk: assert (result[MSB] == operand[MSB] && c_out == operand[0]);
    // R6
    if (sh_acc)
      acc_flags_chk: assert (!z_out && !n_out && !h_out && result_we);
    // R8
    if (op == OP_BTEST)
      btest_chk: assert (!result_we && h_out && !n_out && c_out == carry_in
                         && result == operand && z_out == !operand[bit_idx]);
    // R9
    if (op == OP_BSET || op == OP_BCLR)
      bitwr_chk: assert (z_out == z_in && n_out == n_in && h_out == h_in
                         && c_out == carry_in && result[bit_idx] == (op == OP_BSET));
  end
endmodule

// File: tb/rsb_unit_test.sv
module rsb_unit_test;
  localparam time CLK_P = 10ns;
  localparam int NV = 18;
  // {op,idx,cin,zin,nin,hin,a, res,we,z,n,h,c}
  localparam logic [31:0] VEC [0:NV-1] = '{
    {4'd0, 3'd0,1'b0,3'b111,8'h85, 8'h0B,1'b1,4'b0001},
    {4'd1, 3'd0,1'b0,3'b111,8'h01, 8'h80,1'b1,4'b0001},
    {4'd2, 3'd0,1'b0,3'b000,8'h80, 8'h00,1'b1,4'b1001},
    {4'd3, 3'd0,1'b1,3'b000,8'h01, 8'h80,1'b1,4'b0001},
    {4'd4, 3'd0,1'b1,3'b011,8'hFF, 8'hFE,1'b1,4'b0001},
    {4'd5, 3'd0,1'b0,3'b000,8'h81, 8'hC0,1'b1,4'b0001},
    {4'd6, 3'd0,1'b0,3'b000,8'h01, 8'h00,1'b1,4'b1001},
    {4'd7, 3'd0,1'b1,3'b011,8'hF0, 8'h0F,1'b1,4'b0000},
    {4'd7, 3'd0,1'b1,3'b000,8'h00, 8'h00,1'b1,4'b1000},
    {4'd8, 3'd0,1'b1,3'b111,8'h00, 8'h00,1'b1,4'b0000},
    {4'd9, 3'd0,1'b0,3'b000,8'h01, 8'h80,1'b1,4'b0001},
    {4'd10,3'd0,1'b0,3'b100,8'h80, 8'h00,1'b1,4'b0001},
    {4'd11,3'd0,1'b1,3'b000,8'h00, 8'h80,1'b1,4'b0000},
    {4'd12,3'd7,1'b1,3'b010,8'h7F, 8'h7F,1'b0,4'b1011},
    {4'd12,3'd0,1'b0,3'b100,8'h01, 8'h01,1'b0,4'b0010},
    {4'd13,3'd3,1'b1,3'b101,8'h00, 8'h08,1'b1,4'b1011},
    {4'd14,3'd7,1'b0,3'b010,8'hFF, 8'h7F,1'b1,4'b0100},
    {4'd15,3'd2,1'b1,3'b011,8'h5A, 8'h5A,1'b0,4'b0111}
  };

  logic       clk = 1'b0;
  logic [7:0] operand, result;
  logic [2:0] bit_idx;
  logic [3:0] op_sel;
  logic       carry_in, z_in, n_in, h_in;
  logic       result_we, z_out, n_out, h_out, c_out;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rsb_unit uut (
    .operand(operand), .bit_idx(bit_idx), .carry_in(carry_in),
    .z_in(z_in), .n_in(n_in), .h_in(h_in), .op_sel(op_sel),
    .result(result), .result_we(result_we), .z_out(z_out),
    .n_out(n_out), .h_out(h_out), .c_out(c_out)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:     return "R1/R5";
      4'd2, 4'd3:     return "R2/R5";
      4'd4:           return "R3/R5";
      4'd5, 4'd6:     return "R4/R5";
      4'd7:           return "R7/R5";
      4'd8, 4'd9:     return "R1/R6";
      4'd10, 4'd11:   return "R2/R6";
      4'd12:          return "R8/R10";
      4'd13, 4'd14:   return "R9/R10/R12";
      default:        return "R11";
    endcase
  endfunction

  // Expected {res,we,z,n,h,c} built from the requirement text
  function automatic logic [12:0] model(input logic [3:0] o, input logic [2:0] ix,
      input logic ci, input logic zi, input logic ni, input logic hi, input logic [7:0] a);
    logic [7:0] r;
    logic c;
    bit acc;
    acc = (o >= 4'd8 && o <= 4'd11);
    c = 1'b0;
    r = a;
    case (o)
      4'd0, 4'd8:  begin r = {a[6:0], a[7]}; c = a[7]; end
      4'd1, 4'd9:  begin r = {a[0], a[7:1]}; c = a[0]; end
      4'd2, 4'd10: begin r = {a[6:0], ci};   c = a[7]; end
      4'd3, 4'd11: begin r = {ci, a[7:1]};   c = a[0]; end
      4'd4:        begin r = {a[6:0], 1'b0}; c = a[7]; end
      4'd5:        begin r = {a[7], a[7:1]}; c = a[0]; end
      4'd6:        begin r = {1'b0, a[7:1]}; c = a[0]; end
      4'd7:        begin r = {a[3:0], a[7:4]}; c = 1'b0; end
      default: ;
    endcase
    if (o <= 4'd11)
      return {r, 1'b1, (acc ? 1'b0 : (r == 8'h00)), 1'b0, 1'b0, c};
    else if (o == 4'd12)
      return {a, 1'b0, ~a[ix], 1'b0, 1'b1, ci};
    else if (o == 4'd13) begin
      r = a; r[ix] = 1'b1;
      return {r, 1'b1, zi, ni, hi, ci};
    end else if (o == 4'd14) begin
      r = a; r[ix] = 1'b0;
      return {r, 1'b1, zi, ni, hi, ci};
    end
    return {a, 1'b0, zi, ni, hi, ci};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [2:0] ix, input logic ci,
      input logic [2:0] znh, input logic [7:0] a);
    @(posedge clk);
    op_sel = o; bit_idx = ix; carry_in = ci;
    {z_in, n_in, h_in} = znh; operand = a;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [12:0] exp);
    logic [12:0] act;
    act = {result, result_we, z_out, n_out, h_out, c_out};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h idx=%0d: got %h expected %h",
               tag, op_sel, operand, bit_idx, act, exp);
    end
  endtask

  initial begin
    op_sel = 4'd15; bit_idx = '0; carry_in = 1'b0;
    {z_in, n_in, h_in} = 3'b000; operand = 8'h00;
    // R11: idle code at start passes the operand and flags through
    @(negedge clk);
    check("R11 idle", {8'h00, 1'b0, 4'b0000});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:28], VEC[i][27:25], VEC[i][24], VEC[i][23:21], VEC[i][20:13]);
      check(req_of(VEC[i][31:28]), VEC[i][12:0]);
    end

    // R10: each index addresses its own bit for set
    for (int k = 0; k < 8; k++) begin
      apply(4'd13, 3'(k), 1'b0, 3'b000, 8'h00);
      check("R10 set index", {8'h01 << k, 1'b1, 4'b0000});
    end

    // Exhaustive sweep against the requirement model
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int ci = 0; ci < 2; ci++)
          for (int ix = 0; ix < 8; ix++) begin
            if (o < 12 || o == 15) begin
              if (ix != 0) continue;
            end
            apply(4'(o), 3'(ix), 1'(ci), 3'(a + ix), 8'(a));
            check(req_of(4'(o)), model(4'(o), 3'(ix), 1'(ci),
                  z_in, n_in, h_in, 8'(a)));
          end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule